// File: doc/BRIEF.md
# Write Acknowledge Token and Busy Monitor

This block sits on the card side of an SD/MMC host data path and follows the short exchange that ends every write block. After the host has sent its last data bit, a start pulse arms the monitor. The monitor then watches only the DAT0 line, at each rising edge of the card clock (marked by a clock-enable strobe). It waits for the card's low start bit and collects three status bits. It checks that a high end bit follows, then classifies the status as an error-free receipt, a CRC failure or an unrecognised pattern.

Once the status frame has been read, the card holds DAT0 low for as long as it is busy programming the block. The monitor reports busy for that whole time. When the line returns high it emits a single done pulse. A programmable limit, counted in card-clock ticks, bounds both the wait for the start bit and the busy hold. When the limit is reached the monitor raises a timeout flag, pulses done and goes idle. The result flags stay valid until the next start pulse clears them.

Top module: `wr_ack_monitor`

## Requirements
- R1: After reset, all six outputs (`ack_good`, `ack_crc_err`, `ack_bad`, `busy`, `timed_out`, `done`) are low and the monitor is idle.
- R2: DAT0 is sampled only in cycles where `clk_en` is high. The DAT0 value in other cycles has no effect on any output.
- R3: Once armed, the monitor waits for a low start bit, then takes the next three ticks as status bits (first received bit is the most significant), then takes one more tick as the end bit.
- R4: Status bits 3'b010 with a high end bit set `ack_good` in the cycle after the end-bit tick.
- R5: Status bits 3'b101 with a high end bit set `ack_crc_err` in the cycle after the end-bit tick.
- R6: Any other status value, or a low end bit, sets `ack_bad`. At most one of the three result flags is high at any time.
- R7: `busy` goes high in the cycle after the end-bit tick. It stays high while ticks sample DAT0 low and drops in the cycle after the first tick that samples DAT0 high.
- R8: While waiting for the start bit, if `tmo_limit` consecutive ticks sample DAT0 high, `timed_out` and `done` are set in the cycle after the last of those ticks and the monitor goes idle. A start bit on the tick after `tmo_limit`-1 high ticks causes no timeout.
- R9: While busy, if `tmo_limit` ticks sample DAT0 low, `timed_out` and `done` are set, `busy` drops and the result flag is kept. A release after `tmo_limit`-1 low ticks causes no timeout.
- R10: `done` is high for exactly one cycle per armed transfer, either after the busy release or on a timeout.
- R11: `start` clears all result flags, `timed_out` and `busy` in the next cycle and re-arms the monitor from any state.
- R12: A `tmo_limit` of 0 behaves as 1: the first high tick while waiting for the start bit times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Card clock rising-edge strobe; DAT0 is sampled in these cycles |
| dat0 | input | 1 | Card DAT0 line level |
| start | input | 1 | One-cycle arm pulse issued after the write block is sent |
| tmo_limit | input | CNT_W | Timeout limit in card-clock ticks |
| ack_good | output | 1 | Card reported an error-free block |
| ack_crc_err | output | 1 | Card reported a CRC error |
| ack_bad | output | 1 | Status frame not recognised |
| busy | output | 1 | Card is holding DAT0 low |
| timed_out | output | 1 | Start bit or busy release did not arrive in time |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the two timeout boundaries. It sends exactly `tmo_limit`-1 and exactly `tmo_limit` idle or busy ticks, because an off-by-one counter would either time out on a legal card or wait one tick too long. It interleaves non-strobe cycles that carry the inverted DAT0 level. A monitor that ignored `clk_en` would then decode the wrong token or release busy too early. It also re-arms in the middle of busy and checks a low end bit, limit zero, and that `done` lasts only one cycle, to catch stale flags, a missing restart, and a done level stuck high.

// File: rtl/wr_ack_pkg.sv
package wr_ack_pkg;

   localparam int unsigned TOKEN_W = 3;
   localparam logic [TOKEN_W-1:0] PAT_GOOD = 3'b010;
   localparam logic [TOKEN_W-1:0] PAT_CRC  = 3'b101;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_STAT,
      ST_STOP,
      ST_BUSY
   } ack_state_t;

   typedef enum logic [1:0] {
      ACK_NONE,
      ACK_GOOD,
      ACK_CRC,
      ACK_BAD
   } ack_code_t;

   // Classify the status pattern together with the closing bit.
   function automatic ack_code_t ack_classify(input logic [TOKEN_W-1:0] pat,
                                              input logic stop_bit);
      ack_code_t res;
      if (!stop_bit)            res = ACK_BAD;
      else if (pat == PAT_GOOD) res = ACK_GOOD;
      else if (pat == PAT_CRC)  res = ACK_CRC;
      else                      res = ACK_BAD;
      return res;
   endfunction

endpackage

// File: rtl/wr_ack_shift.sv
module wr_ack_shift #(
   parameter int unsigned W         = 3,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] pat,
   output logic         last
);

   localparam int unsigned CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_width
      $error("wr_ack_shift: W must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  sr_q;
   logic [W-1:0]  sr_nxt;

   // Which end the newest bit enters decides bit order in pat.
   if (MSB_FIRST) begin : g_msb
      assign sr_nxt = {sr_q[W-2:0], bit_in};
   end else begin : g_lsb
      assign sr_nxt = {bit_in, sr_q[W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         sr_q <= sr_nxt;
         if (cnt_q != CW'(W)) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pat  = sr_q;
   assign last = (cnt_q == CW'(W - 1));

   // R2: the pattern only moves on a strobed shift
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !clr) |=> $stable(pat));

endmodule

// File: rtl/wr_ack_timer.sv
module wr_ack_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         hit
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   if (W < 2) begin : g_bad_width
      $error("wr_ack_timer: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_plus;

   assign cnt_plus = {1'b0, cnt_q} + 1'b1;
   // A limit of zero compares below any count, so it acts as one.
   assign hit = inc && (cnt_plus >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clr)                     cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   // R9: the tick counter saturates instead of wrapping
   p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/wr_ack_monitor.sv
module wr_ack_monitor
   import wr_ack_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter bit          DAT0_REG  = 1'b0,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             dat0,
   input  logic             start,
   input  logic [CNT_W-1:0] tmo_limit,
   output logic             ack_good,
   output logic             ack_crc_err,
   output logic             ack_bad,
   output logic             busy,
   output logic             timed_out,
   output logic             done
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("wr_ack_monitor: CNT_W must be at least 2");
   end

   logic       dat_s;
   ack_state_t state_q;
   logic       good_q, crc_q, bad_q, tmo_q, done_q;
   logic       sh_en, sh_last;
   logic [TOKEN_W-1:0] pat;
   logic       tm_clr, tm_inc, tm_hit;
   ack_code_t  code;

   // Optional input stage: sample DAT0 once more on each strobe.
   if (DAT0_REG) begin : g_dat_reg
      logic dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dat_q <= 1'b1;
         else if (clk_en) dat_q <= dat0;
      end
      assign dat_s = dat_q;
   end else begin : g_dat_thru
      assign dat_s = dat0;
   end

   assign sh_en  = clk_en && (state_q == ST_STAT);
   assign tm_clr = start || (clk_en && state_q == ST_STOP);
   assign tm_inc = clk_en && ((state_q == ST_HUNT &&  dat_s) ||
                              (state_q == ST_BUSY && !dat_s));
   assign code   = ack_classify(pat, dat_s);

   wr_ack_shift #(.W(TOKEN_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .shift_en (sh_en),
      .bit_in   (dat_s),
      .pat      (pat),
      .last     (sh_last)
   );

   wr_ack_timer #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tm_clr),
      .inc   (tm_inc),
      .limit (tmo_limit),
      .hit   (tm_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         good_q  <= 1'b0;
         crc_q   <= 1'b0;
         bad_q   <= 1'b0;
         tmo_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            state_q <= ST_HUNT;
            good_q  <= 1'b0;
            crc_q   <= 1'b0;
            bad_q   <= 1'b0;
            tmo_q   <= 1'b0;
         end else if (clk_en) begin
            unique case (state_q)
               ST_HUNT: begin
                  if (!dat_s) begin
                     state_q <= ST_STAT;
                  end else if (tm_hit) begin
                     state_q <= ST_IDLE;
                     tmo_q   <= 1'b1;
                     done_q  <= 1'b1;
                  end
               end
               ST_STAT: begin
                  if (sh_last) state_q <= ST_STOP;
               end
               ST_STOP: begin
                  good_q  <= (code == ACK_GOOD);
                  crc_q   <= (code == ACK_CRC);
                  bad_q   <= (code == ACK_BAD);
                  state_q <= ST_BUSY;
               end
               ST_BUSY: begin
                  if (dat_s) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else if (tm_hit) begin
                     state_q <= ST_IDLE;
                     tmo_q   <= 1'b1;
                     done_q  <= 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign ack_good    = good_q;
   assign ack_crc_err = crc_q;
   assign ack_bad     = bad_q;
   assign busy        = (state_q == ST_BUSY);
   assign timed_out   = tmo_q;
   assign done        = done_q;

   // R6: never more than one verdict at a time
   p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack_good, ack_crc_err, ack_bad}));

   // R10: completion is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: a high sample during busy ends busy and completes
   p_busy_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && clk_en && dat_s && !start) |=> (!busy && done));

   // R11: arming wipes every result
   p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!ack_good && !ack_crc_err && !ack_bad && !timed_out && !busy && !done));

   // R8: a timeout always comes with completion
   p_tmo_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timed_out) |-> done);

endmodule

// File: tb/wr_ack_monitor_bench.sv
module wr_ack_monitor_bench;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clk_en = 1'b0;
   logic             dat0 = 1'b1;
   logic             start = 1'b0;
   logic [CNT_W-1:0] tmo_limit = 16'd50;
   logic ack_good, ack_crc_err, ack_bad, busy, timed_out, done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wr_ack_monitor #(.CNT_W(CNT_W)) u_wr_ack_monitor (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dat0(dat0), .start(start),
      .tmo_limit(tmo_limit), .ack_good(ack_good), .ack_crc_err(ack_crc_err),
      .ack_bad(ack_bad), .busy(busy), .timed_out(timed_out), .done(done)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // outputs packed as {good,crc,bad,busy,tmo,done}
   function automatic logic [7:0] outs();
      return {2'b00, ack_good, ack_crc_err, ack_bad, busy, timed_out, done};
   endfunction

   task automatic tick(input logic d);
      @(negedge clk);
      clk_en = 1'b1;
      dat0   = d;
      @(posedge clk);
   endtask

   // tick preceded by a non-strobe cycle carrying the opposite level
   task automatic tick_gap(input logic d);
      @(negedge clk);
      clk_en = 1'b0;
      dat0   = ~d;
      @(posedge clk);
      tick(d);
   endtask

   task automatic settle();
      @(negedge clk);
      clk_en = 1'b0;
      dat0   = 1'b1;
   endtask

   task automatic arm();
      @(negedge clk);
      clk_en = 1'b0;
      start  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send_frame(input logic [2:0] pat, input logic stop);
      tick(1'b0);
      for (int i = 2; i >= 0; i--) tick(pat[i]);
      tick(stop);
      settle();
   endtask

   task automatic t_reset();
      check("R1", "outputs after reset", outs(), 8'h00);
   endtask

   task automatic t_good();
      tmo_limit = 16'd50;
      arm();
      tick(1'b1); tick(1'b1);
      send_frame(3'b010, 1'b1);
      check("R4", "good token flags", outs(), 8'b0010_0100);
      for (int i = 0; i < 3; i++) begin
         tick(1'b0); settle();
         check("R7", "busy held while low", outs(), 8'b0010_0100);
      end
      tick(1'b1); settle();
      check("R7", "release ends busy with done", outs(), 8'b0010_0001);
      settle();
      check("R10", "done single cycle", outs(), 8'b0010_0000);
   endtask

   task automatic t_crc();
      arm();
      send_frame(3'b101, 1'b1);
      check("R5", "crc token flags", outs(), 8'b0001_0100);
      tick(1'b1); settle();
      check("R7", "immediate release", outs(), 8'b0001_0001);
   endtask

   task automatic t_bad();
      arm();
      send_frame(3'b110, 1'b1);
      check("R6", "unknown pattern", outs(), 8'b0000_1100);
      tick(1'b1); settle();
      arm();
      send_frame(3'b010, 1'b0);
      check("R6", "low end bit", outs(), 8'b0000_1100);
      tick(1'b1); settle();
      check("R6", "release after bad frame", outs(), 8'b0000_1001);
   endtask

   task automatic t_restart();
      arm();
      check("R11", "start clears flags", outs(), 8'h00);
      send_frame(3'b101, 1'b1);
      tick(1'b0); settle();
      arm();
      check("R11", "start during busy", outs(), 8'h00);
      send_frame(3'b010, 1'b1);
      check("R3", "frame after restart", outs(), 8'b0010_0100);
      tick(1'b1); settle();
   endtask

   task automatic t_hunt_tmo();
      tmo_limit = 16'd4;
      arm();
      for (int i = 0; i < 3; i++) tick(1'b1);
      settle();
      check("R8", "no timeout at limit-1", outs(), 8'h00);
      tick(1'b1); settle();
      check("R8", "timeout at limit", outs(), 8'b0000_0011);
      settle();
      check("R10", "done drops after timeout", outs(), 8'b0000_0010);
      tick(1'b0); tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b1); settle();
      check("R8", "idle after timeout ignores line", outs(), 8'b0000_0010);
   endtask

   task automatic t_hunt_edge();
      tmo_limit = 16'd4;
      arm();
      for (int i = 0; i < 3; i++) tick(1'b1);
      send_frame(3'b010, 1'b1);
      check("R8", "late start bit accepted", outs(), 8'b0010_0100);
      tick(1'b1); settle();
   endtask

   task automatic t_busy_tmo();
      tmo_limit = 16'd4;
      arm();
      send_frame(3'b010, 1'b1);
      for (int i = 0; i < 3; i++) tick(1'b0);
      settle();
      check("R9", "busy at limit-1", outs(), 8'b0010_0100);
      tick(1'b0); settle();
      check("R9", "busy timeout", outs(), 8'b0010_0011);
      arm();
      send_frame(3'b010, 1'b1);
      for (int i = 0; i < 3; i++) tick(1'b0);
      tick(1'b1); settle();
      check("R9", "release at limit-1 no timeout", outs(), 8'b0010_0001);
   endtask

   task automatic t_gating();
      tmo_limit = 16'd4;
      arm();
      tick_gap(1'b0);
      tick_gap(1'b0); tick_gap(1'b1); tick_gap(1'b0);
      tick_gap(1'b1);
      settle();
      check("R2", "gated frame decodes", outs(), 8'b0010_0100);
      for (int i = 0; i < 3; i++) tick_gap(1'b0);
      settle();
      check("R2", "gated busy holds", outs(), 8'b0010_0100);
      tick_gap(1'b1); settle();
      check("R2", "gated release", outs(), 8'b0010_0001);
   endtask

   task automatic t_zero_limit();
      tmo_limit = 16'd0;
      arm();
      tick(1'b1); settle();
      check("R12", "zero limit times out on first tick", outs(), 8'b0000_0011);
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_good();
      t_crc();
      t_bad();
      t_restart();
      t_hunt_tmo();
      t_hunt_edge();
      t_busy_tmo();
      t_gating();
      t_zero_limit();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule